// File: doc/BRIEF.md
# DMA Transfer Submission Register Front-End

This block is the register-facing control side of a single-channel DMA engine. Software first stages the parameters of one transfer in a set of registers: source address, destination address, row length, row count and flags. It then writes a commit register, which pushes a snapshot of those values into a small descriptor queue. Each committed transfer receives a 5-bit tag taken from a wrapping counter. Software reads that tag before it commits, and later finds the finished tag as a bit in a completion bitmask.

The head of the queue is offered to a data mover through a valid/ready handshake. The mover reports each finished transfer by pulsing its tag back to the block. Two interrupt events are raised: a commit event when a request enters the queue, and a completion event when a tag is reported done. Both pass through a mask.

Hardware options are fixed by parameters. Software discovers them by writing a register and reading it back:
- The cyclic flag reads back zero when cyclic support is absent.
- The row-count register reads back zero when two-dimensional support is absent.
- An address register reads back zero when its side is a streaming port rather than memory.
- The row-length register exposes both the maximum length and the alignment granule.

A read-only word describes the kind and width of each side.

Top module: `dmasub_top`

## Requirements
- R1: After reset the tag register (0x404) reads 0, the completion mask (0x428) reads 0, the interrupt mask (0x80) reads 3 (both events masked), control (0x400) reads 0, the commit register (0x408) reads 0, and `irq` and `descValid` are low.
- R2: Writing a value with bit 0 set to 0x408 while the engine is enabled queues the staged parameters under the tag that 0x404 showed before the write. The tag register then advances by one modulo 32 (31 is followed by 0). Queued descriptors appear on the desc* outputs in commit order.
- R3: The queue holds 4 descriptors. A commit made while it is full stays pending and 0x408 reads 1 until a slot frees; the commit is then accepted with its tag unchanged.
- R4: A pulse on `doneValid` sets bit `doneId` of 0x428. Committing a tag clears that tag's bit. Bit 31 additionally reads 1 while `partialFlag` is high.
- R5: The raw event register (0x88) latches bit 0 on every accepted commit and bit 1 on every completion pulse. Pending (0x84) reads raw & ~mask. Writing 1s to 0x84 clears those raw bits, but an event arriving in the same cycle keeps its bit set. `irq` is high exactly when pending is nonzero.
- R6: Control bit 0 enables and bit 1 pauses. `descValid` is high only when enabled, not paused and the queue is non-empty. A commit made while disabled waits. Writing control with bit 0 clear empties the queue and drops a waiting commit.
- R7: Flags (0x40c) keep bit 1 (last segment) and bit 2 (partial-length reporting). Bit 0 (cyclic) reads back 0 with cyclic support absent, which is the default.
- R8: The row-length register (0x418) keeps LEN_W bits with the low alignment bits forced to 1. With defaults, writing all ones reads 0x00FFFFFF and writing 0 reads 0x7 (granule of 8 bytes, the wider side).
- R9: With defaults, the row-count register (0x41c) reads 0 (no 2D support) and the destination address (0x410) reads 0 (streaming side). The source address (0x414) reads back as written.
- R10: Address 0x10 reads source kind in bits 13:12, source width log2 bytes in 11:8, destination kind in 5:4 and destination width log2 in 3:0. Kind 0 is memory, 1 is stream and 2 is FIFO. With defaults the word is 0x00000322.
- R11: Register 0x42c returns the tag of the last descriptor accepted by the data mover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Byte address for read and write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| descValid | output | 1 | Queue head offered to the data mover |
| descReady | input | 1 | Data mover accepts the head |
| descId | output | 5 | Tag of the head descriptor |
| descSrcAddr | output | 32 | Source address of the head |
| descDstAddr | output | 32 | Destination address of the head |
| descXLen | output | 32 | Row length minus one of the head |
| descYLen | output | 32 | Row count minus one of the head |
| descFlags | output | 3 | Flags of the head |
| doneValid | input | 1 | Completion pulse from the data mover |
| doneId | input | 5 | Tag of the completed transfer |
| partialFlag | input | 1 | Partial-length report pending |
| irq | output | 1 | Interrupt request |

## Verification
The collision that matters is a completion pulse arriving in the same cycle as a software write that clears the completion bit in the pending register. The bench drives `doneValid` and the clearing write on one clock edge. It then expects the pending bit to stay set, and expects a later plain write to clear it. A second overlap, a commit request that meets a disabling control write, is provoked by queuing work and then writing control to 0. The bench judges it by `descValid` staying low and the commit register reading 0 after re-enabling.

// File: rtl/dmasub_pkg.sv
package dmasub_pkg;
  localparam int ID_W   = 5;
  localparam int FLAG_W = 3;

  // register byte offsets as software decodes them
  localparam logic [11:0] OFS_IFDESC = 12'h010;
  localparam logic [11:0] OFS_IMASK  = 12'h080;
  localparam logic [11:0] OFS_IPEND  = 12'h084;
  localparam logic [11:0] OFS_IRAW   = 12'h088;
  localparam logic [11:0] OFS_CTRL   = 12'h400;
  localparam logic [11:0] OFS_TAG    = 12'h404;
  localparam logic [11:0] OFS_COMMIT = 12'h408;
  localparam logic [11:0] OFS_FLAGS  = 12'h40c;
  localparam logic [11:0] OFS_DST    = 12'h410;
  localparam logic [11:0] OFS_SRC    = 12'h414;
  localparam logic [11:0] OFS_XLEN   = 12'h418;
  localparam logic [11:0] OFS_YLEN   = 12'h41c;
  localparam logic [11:0] OFS_DONE   = 12'h428;
  localparam logic [11:0] OFS_ACTIVE = 12'h42c;

  typedef enum logic [1:0] {
    KIND_MEM    = 2'd0,
    KIND_STREAM = 2'd1,
    KIND_FIFO   = 2'd2
  } sideKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ldSrc;
    logic ldDst;
    logic ldX;
    logic ldY;
    logic ldFlags;
    logic commit;
    logic flush;
    logic pop;
  } stb_t;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [31:0]       src;
    logic [31:0]       dst;
    logic [31:0]       xLen;
    logic [31:0]       yLen;
    logic [FLAG_W-1:0] flags;
  } entry_t;
endpackage

// File: rtl/dmasub_ctrl.sv
module dmasub_ctrl
  import dmasub_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWrEn,
  input  logic [11:0]     regAddr,
  input  logic [1:0]      wrLow,
  input  logic            queueFull,
  input  logic            queueEmpty,
  input  logic            descReady,
  input  logic            doneValid,
  output stb_t            stb,
  output logic            descValid,
  output logic            enable,
  output logic            pause,
  output logic            startPend,
  output logic [ID_W-1:0] nextId,
  output logic [1:0]      irqMask,
  output logic [1:0]      irqRaw,
  output logic            irq
);
  logic wrCtrl, wrStart, wrMask, wrPend;

  always_comb begin
    wrCtrl      = regWrEn && (regAddr == OFS_CTRL);
    wrStart     = regWrEn && (regAddr == OFS_COMMIT);
    wrMask      = regWrEn && (regAddr == OFS_IMASK);
    wrPend      = regWrEn && (regAddr == OFS_IPEND);
    stb.ldSrc   = regWrEn && (regAddr == OFS_SRC);
    stb.ldDst   = regWrEn && (regAddr == OFS_DST);
    stb.ldX     = regWrEn && (regAddr == OFS_XLEN);
    stb.ldY     = regWrEn && (regAddr == OFS_YLEN);
    stb.ldFlags = regWrEn && (regAddr == OFS_FLAGS);
    stb.flush   = wrCtrl && !wrLow[0];
    stb.commit  = startPend && enable && !queueFull && !stb.flush;
    descValid   = !queueEmpty && enable && !pause;
    stb.pop     = descValid && descReady;
    irq         = |(irqRaw & ~irqMask);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable    <= 1'b0;
      pause     <= 1'b0;
      startPend <= 1'b0;
      nextId    <= '0;
      irqMask   <= 2'b11;
      irqRaw    <= 2'b00;
    end else begin
      if (wrCtrl) {pause, enable} <= wrLow;
      if (wrMask) irqMask <= wrLow;
      if (stb.flush)                startPend <= 1'b0;
      else if (wrStart && wrLow[0]) startPend <= 1'b1;
      else if (stb.commit)          startPend <= 1'b0;
      if (stb.commit) nextId <= nextId + 1'b1;
      // new events win over a same-cycle clear
      irqRaw <= (irqRaw & ~(wrPend ? wrLow : 2'b00)) | {doneValid, stb.commit};
    end
  end
endmodule

// File: rtl/dmasub_dpath.sv
module dmasub_dpath
  import dmasub_pkg::*;
#(
  parameter int QDEPTH     = 4,
  parameter int LEN_W      = 24,
  parameter int SRC_KIND   = 0,
  parameter int DST_KIND   = 2,
  parameter int SRC_WLOG2  = 3,
  parameter int DST_WLOG2  = 2,
  parameter bit HAS_CYCLIC = 1'b0,
  parameter bit HAS_2D     = 1'b0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  stb_t                         stb,
  input  logic [31:0]                  wrData,
  input  logic [11:0]                  rdAddr,
  input  logic [ID_W-1:0]              nextId,
  input  logic                         doneValid,
  input  logic [ID_W-1:0]              doneId,
  input  logic                         partialFlag,
  input  logic                         enable,
  input  logic                         pause,
  input  logic                         startPend,
  input  logic [1:0]                   irqMask,
  input  logic [1:0]                   irqRaw,
  output logic                         queueFull,
  output logic                         queueEmpty,
  output logic [$clog2(QDEPTH+1)-1:0]  queueCount,
  output entry_t                       head,
  output logic [ID_W-1:0]              activeId,
  output logic [31:0]                  doneMask,
  output logic [31:0]                  rdData
);
  localparam int          PTR_W      = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int          CNT_W      = $clog2(QDEPTH + 1);
  localparam int          ALIGN_LOG2 = (SRC_WLOG2 > DST_WLOG2) ? SRC_WLOG2 : DST_WLOG2;
  localparam logic [31:0] ALIGN_MASK = 32'((64'd1 << ALIGN_LOG2) - 1);
  localparam logic [31:0] LEN_MASK   = 32'((64'd1 << LEN_W) - 1);
  localparam logic [2:0]  FLAG_KEEP  = HAS_CYCLIC ? 3'b111 : 3'b110;
  localparam logic [31:0] IF_WORD    = (32'(SRC_KIND & 3) << 12) | (32'(SRC_WLOG2 & 15) << 8)
                                     | (32'(DST_KIND & 3) << 4)  | 32'(DST_WLOG2 & 15);

  logic [31:0]       srcQ, dstQ, xQ, yQ;
  logic [2:0]        flagsQ;
  entry_t            qMem [QDEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  cnt;
  logic [31:0]       doneQ;
  entry_t            newEntry;

  function automatic logic [PTR_W-1:0] ptrNext(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // address staging only exists on a memory-mapped side
  if (SRC_KIND == 0) begin : g_srcMem
    always_ff @(posedge clk)
      if (!rstN) srcQ <= '0;
      else if (stb.ldSrc) srcQ <= wrData;
  end else begin : g_srcNone
    assign srcQ = '0;
  end

  if (DST_KIND == 0) begin : g_dstMem
    always_ff @(posedge clk)
      if (!rstN) dstQ <= '0;
      else if (stb.ldDst) dstQ <= wrData;
  end else begin : g_dstNone
    assign dstQ = '0;
  end

  if (HAS_2D) begin : g_rows
    always_ff @(posedge clk)
      if (!rstN) yQ <= '0;
      else if (stb.ldY) yQ <= wrData & LEN_MASK;
  end else begin : g_noRows
    assign yQ = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xQ     <= ALIGN_MASK;
      flagsQ <= '0;
    end else begin
      if (stb.ldX)     xQ     <= (wrData & LEN_MASK) | ALIGN_MASK;
      if (stb.ldFlags) flagsQ <= wrData[2:0] & FLAG_KEEP;
    end
  end

  assign newEntry = '{id: nextId, src: srcQ, dst: dstQ, xLen: xQ, yLen: yQ, flags: flagsQ};

  always_ff @(posedge clk)
    if (stb.commit) qMem[wrPtr] <= newEntry;

  always_ff @(posedge clk) begin
    if (!rstN || stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (stb.commit) wrPtr <= ptrNext(wrPtr);
      if (stb.pop)    rdPtr <= ptrNext(rdPtr);
      cnt <= cnt + CNT_W'(stb.commit) - CNT_W'(stb.pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ    <= '0;
      activeId <= '0;
    end else begin
      if (stb.commit) doneQ[nextId] <= 1'b0;
      if (doneValid)  doneQ[doneId] <= 1'b1;
      if (stb.pop)    activeId      <= head.id;
    end
  end

  assign head       = qMem[rdPtr];
  assign queueCount = cnt;
  assign queueFull  = (cnt == CNT_W'(QDEPTH));
  assign queueEmpty = (cnt == '0);
  assign doneMask   = doneQ | {partialFlag, 31'b0};

  always_comb begin
    unique case (rdAddr)
      OFS_IFDESC: rdData = IF_WORD;
      OFS_IMASK:  rdData = {30'b0, irqMask};
      OFS_IPEND:  rdData = {30'b0, irqRaw & ~irqMask};
      OFS_IRAW:   rdData = {30'b0, irqRaw};
      OFS_CTRL:   rdData = {30'b0, pause, enable};
      OFS_TAG:    rdData = 32'(nextId);
      OFS_COMMIT: rdData = {31'b0, startPend};
      OFS_FLAGS:  rdData = {29'b0, flagsQ};
      OFS_DST:    rdData = dstQ;
      OFS_SRC:    rdData = srcQ;
      OFS_XLEN:   rdData = xQ;
      OFS_YLEN:   rdData = yQ;
      OFS_DONE:   rdData = doneMask;
      OFS_ACTIVE: rdData = 32'(activeId);
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/dmasub_top.sv
module dmasub_top
  import dmasub_pkg::*;
#(
  parameter int QDEPTH     = 4,
  parameter int LEN_W      = 24,
  parameter int SRC_KIND   = 0,
  parameter int DST_KIND   = 2,
  parameter int SRC_WLOG2  = 3,
  parameter int DST_WLOG2  = 2,
  parameter bit HAS_CYCLIC = 1'b0,
  parameter bit HAS_2D     = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [11:0] regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        descValid,
  input  logic        descReady,
  output logic [4:0]  descId,
  output logic [31:0] descSrcAddr,
  output logic [31:0] descDstAddr,
  output logic [31:0] descXLen,
  output logic [31:0] descYLen,
  output logic [2:0]  descFlags,
  input  logic        doneValid,
  input  logic [4:0]  doneId,
  input  logic        partialFlag,
  output logic        irq
);
  stb_t                        stb;
  logic                        queueFull, queueEmpty;
  logic [$clog2(QDEPTH+1)-1:0] queueCount;
  logic                        enable, pause, startPend;
  logic [ID_W-1:0]             nextId, activeId;
  logic [1:0]                  irqMask, irqRaw;
  logic [31:0]                 doneMask;
  entry_t                      head;

  dmasub_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .wrLow(regWrData[1:0]), .queueFull(queueFull), .queueEmpty(queueEmpty),
    .descReady(descReady), .doneValid(doneValid), .stb(stb),
    .descValid(descValid), .enable(enable), .pause(pause),
    .startPend(startPend), .nextId(nextId), .irqMask(irqMask),
    .irqRaw(irqRaw), .irq(irq)
  );

  dmasub_dpath #(
    .QDEPTH(QDEPTH), .LEN_W(LEN_W), .SRC_KIND(SRC_KIND), .DST_KIND(DST_KIND),
    .SRC_WLOG2(SRC_WLOG2), .DST_WLOG2(DST_WLOG2),
    .HAS_CYCLIC(HAS_CYCLIC), .HAS_2D(HAS_2D)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData), .rdAddr(regAddr),
    .nextId(nextId), .doneValid(doneValid), .doneId(doneId),
    .partialFlag(partialFlag), .enable(enable), .pause(pause),
    .startPend(startPend), .irqMask(irqMask), .irqRaw(irqRaw),
    .queueFull(queueFull), .queueEmpty(queueEmpty), .queueCount(queueCount),
    .head(head), .activeId(activeId), .doneMask(doneMask), .rdData(regRdData)
  );

  assign descId      = head.id;
  assign descSrcAddr = head.src;
  assign descDstAddr = head.dst;
  assign descXLen    = head.xLen;
  assign descYLen    = head.yLen;
  assign descFlags   = head.flags;
endmodule

// File: rtl/dmasub_checker.sv
module dmasub_checker
  import dmasub_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        descValid,
  input logic                        descReady,
  input logic [4:0]                  descId,
  input logic                        doneValid,
  input logic [4:0]                  doneId,
  input logic [$clog2(QDEPTH+1)-1:0] queueCount,
  input logic [31:0]                 doneMask,
  input logic [4:0]                  activeId,
  input logic [1:0]                  irqRaw,
  input stb_t                        stb
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    queueCount <= ($clog2(QDEPTH+1))'(QDEPTH)); // R3

  AST_DONE_SETS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> doneMask[$past(doneId)]); // R4

  AST_EOT_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> irqRaw[1]); // R5

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    stb.flush |=> (queueCount == '0) && !descValid); // R6

  AST_ACTIVE_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && descReady) |=> activeId == $past(descId)); // R11
endmodule

bind dmasub_top dmasub_checker #(.QDEPTH(QDEPTH)) i_dmasubChk (
  .clk(clk), .rstN(rstN), .descValid(descValid), .descReady(descReady),
  .descId(descId), .doneValid(doneValid), .doneId(doneId),
  .queueCount(queueCount), .doneMask(doneMask), .activeId(activeId),
  .irqRaw(irqRaw), .stb(stb)
);

// File: tb/test_dmasub_top.sv
`timescale 1ns/1ps
module test_dmasub_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        descValid;
  logic        descReady = 1'b0;
  logic [4:0]  descId;
  logic [31:0] descSrcAddr, descDstAddr, descXLen, descYLen;
  logic [2:0]  descFlags;
  logic        doneValid = 1'b0;
  logic [4:0]  doneId = '0;
  logic        partialFlag = 1'b0;
  logic        irq;

  int nChecks = 0;
  int nErrors = 0;

  typedef struct {
    logic [4:0]  id;
    logic [31:0] src;
    logic [31:0] xLen;
    logic [2:0]  flags;
  } expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  dmasub_top i_dmasub_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .descValid(descValid),
    .descReady(descReady), .descId(descId), .descSrcAddr(descSrcAddr),
    .descDstAddr(descDstAddr), .descXLen(descXLen), .descYLen(descYLen),
    .descFlags(descFlags), .doneValid(doneValid), .doneId(doneId),
    .partialFlag(partialFlag), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    @(negedge clk);
    d = regRdData;
  endtask

  task automatic rdChk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic pulseDone(input logic [4:0] id);
    @(posedge clk); #1;
    doneValid = 1'b1; doneId = id;
    @(posedge clk); #1;
    doneValid = 1'b0;
  endtask

  // driver: stage, learn the tag, push expectation, commit
  task automatic commit(input logic [31:0] src, input logic [31:0] x,
                        input logic [2:0] fl, input bit deliver);
    logic [31:0] tag;
    expItem_t it;
    wr(12'h414, src);
    wr(12'h418, x);
    wr(12'h40c, {29'b0, fl});
    rd(12'h404, tag);
    if (deliver) begin
      it.id = tag[4:0]; it.src = src;
      it.xLen = (x & 32'h00FF_FFFF) | 32'h7;
      it.flags = fl & 3'b110;
      expQ.push_back(it);
    end
    wr(12'h408, 32'h1);
    idle(2);
  endtask

  task automatic drain();
    for (int i = 0; i < 200; i++) begin
      if (expQ.size() == 0) break;
      idle(1);
    end
    check("R2 scoreboard drained", 32'(expQ.size()), 32'd0);
  endtask

  // monitor: compare each accepted descriptor against the scoreboard
  always @(negedge clk) begin
    if (rstN && descValid && descReady) begin
      if (expQ.size() == 0) begin
        nChecks++; nErrors++;
        $display("FAIL R2 unexpected descriptor actual=%h expected=none", descId);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check("R2 descriptor id", {27'b0, descId}, {27'b0, e.id});
        check("R2 descriptor src", descSrcAddr, e.src);
        check("R8 descriptor xlen", descXLen, e.xLen);
        check("R7 descriptor flags", {29'b0, descFlags}, {29'b0, e.flags});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] expDone;
    expDone = '0;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    rdChk("R1 tag", 12'h404, 32'd0);
    rdChk("R1 done", 12'h428, 32'd0);
    rdChk("R1 mask", 12'h080, 32'd3);
    rdChk("R1 ctrl", 12'h400, 32'd0);
    rdChk("R1 commit", 12'h408, 32'd0);
    check("R1 irq", {31'b0, irq}, 32'd0);
    check("R1 descValid", {31'b0, descValid}, 32'd0);

    // R10 interface description
    rdChk("R10 ifdesc", 12'h010, 32'h0000_0322);

    // R8 length probe
    wr(12'h418, 32'hFFFF_FFFF);
    rdChk("R8 xlen max", 12'h418, 32'h00FF_FFFF);
    wr(12'h418, 32'h0);
    rdChk("R8 xlen align", 12'h418, 32'h7);
    // R7 flags probe
    wr(12'h40c, 32'h7);
    rdChk("R7 flags", 12'h40c, 32'h6);
    // R9 option probes
    wr(12'h41c, 32'h5);
    rdChk("R9 ylen", 12'h41c, 32'h0);
    wr(12'h410, 32'hABCD_0000);
    rdChk("R9 dst addr", 12'h410, 32'h0);
    wr(12'h414, 32'h0000_1238);
    rdChk("R9 src addr", 12'h414, 32'h0000_1238);

    // R3 fill the queue with the mover stalled
    wr(12'h400, 32'h1);
    wr(12'h080, 32'h0);
    for (int k = 0; k < 4; k++)
      commit(32'h1000 + 32'(k) * 32'h100, 32'h40 + 32'(k), 3'b011, 1'b1);
    rdChk("R2 tag after four", 12'h404, 32'd4);
    rdChk("R5 raw commit event", 12'h088, 32'd1);
    check("R5 irq on commit", {31'b0, irq}, 32'd1);
    commit(32'h2000, 32'h80, 3'b010, 1'b1);
    rdChk("R3 commit waits when full", 12'h408, 32'd1);
    rdChk("R3 tag held", 12'h404, 32'd4);
    descReady = 1'b1;
    drain();
    rdChk("R3 commit accepted", 12'h408, 32'd0);
    rdChk("R11 active tag", 12'h42c, 32'd4);

    // R4 completion mask
    pulseDone(5'd2); expDone |= 32'h4;
    rdChk("R4 done bit", 12'h428, expDone);
    partialFlag = 1'b1;
    idle(1);
    rdChk("R4 partial flag", 12'h428, expDone | 32'h8000_0000);
    partialFlag = 1'b0;

    // R5 completion and clear in the same cycle: event wins
    rdChk("R5 pending both", 12'h084, 32'd3);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = 12'h084; regWrData = 32'h2;
    doneValid = 1'b1; doneId = 5'd3;
    @(posedge clk); #1;
    regWrEn = 1'b0; doneValid = 1'b0;
    expDone |= 32'h8;
    rdChk("R5 set beats clear", 12'h084, 32'd3);
    wr(12'h084, 32'h3);
    rdChk("R5 cleared", 12'h084, 32'd0);
    check("R5 irq low", {31'b0, irq}, 32'd0);
    pulseDone(5'd7); expDone |= 32'h80;
    rdChk("R5 eot pending", 12'h084, 32'd2);
    check("R5 irq high", {31'b0, irq}, 32'd1);
    wr(12'h080, 32'h3);
    rdChk("R5 masked pending", 12'h084, 32'd0);
    rdChk("R5 raw kept", 12'h088, 32'd2);
    check("R5 irq masked", {31'b0, irq}, 32'd0);
    wr(12'h084, 32'h3);
    wr(12'h080, 32'h0);

    // R4 reassigning a tag clears its bit
    pulseDone(5'd5); expDone |= 32'h20;
    rdChk("R4 done id5", 12'h428, expDone);
    commit(32'h3000, 32'h10, 3'b000, 1'b1);
    expDone &= ~32'h20;
    rdChk("R4 cleared on reassign", 12'h428, expDone);
    drain();

    // R6 pause holds the head
    wr(12'h400, 32'h3);
    commit(32'h4000, 32'h20, 3'b100, 1'b1);
    idle(2);
    check("R6 paused no valid", {31'b0, descValid}, 32'd0);
    wr(12'h400, 32'h1);
    drain();

    // R6 disable flushes queue and drops waiting commit
    descReady = 1'b0;
    commit(32'h5000, 32'h30, 3'b000, 1'b0);
    check("R6 queued valid", {31'b0, descValid}, 32'd1);
    wr(12'h400, 32'h0);
    check("R6 flush drops valid", {31'b0, descValid}, 32'd0);
    commit(32'h6000, 32'h30, 3'b000, 1'b0);
    rdChk("R6 commit waits while disabled", 12'h408, 32'd1);
    wr(12'h400, 32'h0);
    rdChk("R6 waiting commit dropped", 12'h408, 32'd0);
    wr(12'h400, 32'h1);
    idle(2);
    check("R6 queue empty after flush", {31'b0, descValid}, 32'd0);
    rdChk("R6 tag after flush", 12'h404, 32'd8);

    // R2 tag wrap 31 -> 0
    descReady = 1'b1;
    rd(12'h404, v);
    while (v != 32'd31) begin
      commit(32'h7000 + v, 32'h8, 3'b010, 1'b1);
      rd(12'h404, v);
    end
    commit(32'h7FF0, 32'h8, 3'b010, 1'b1);
    rdChk("R2 tag wraps", 12'h404, 32'd0);
    drain();
    rdChk("R11 active after wrap", 12'h42c, 32'd31);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule